// File: doc/BRIEF.md
# Decimal Three-to-Two Digit Compressor

This block is the last reduction stage of a decimal multiplier's partial product tree. For every decimal column it takes three 4-bit digits, each of which may hold any value from 0 to 15. It turns them into two digits whose per-column sum a single BCD carry-propagate adder can take directly. The first output digit, A, is coded in excess-6. The second output digit, B, is plain BCD. Each column hands a 2-bit decimal carry to its left neighbour. That carry never travels further than one column, so the logic depth does not depend on the number of columns.

Each column splits its inputs by bit weight. The two upper bits of each digit (weights 8 and 4) are added together with the incoming carry. The result is split into a decimal digit and a carry of weight ten. The two lower bits (weights 2 and 1) are added as a plain binary sum, which can never exceed nine and so is already a valid BCD digit. All results are captured in one bank of registers, so the outputs follow the inputs by one clock cycle. The number of columns is a parameter.

Top module: `dec_csa32`

## Requirements
- R1: Outputs are registered with a latency of one clock cycle. While `rst_n` is low, the clock edge clears `sum_xs6`, `sum_bcd` and `carry_out` to zero.
- R2: For column i (bits 4i+3..4i of every digit vector), the B digit equals the binary sum of bits [1:0] of the three input digits. This sum is always in [0, 9].
- R3: Let U be the sum of bits [3:2] of the three input digits of a column, read as values 0..3, and let c be the column's carry in. The A digit equals ((4U + c) mod 10) + 6, so it always lies in [6, 15].
- R4: The carry out of a column equals floor((4U + c) / 10), a value in 0..3.
- R5: The high bit of a column's carry out is set exactly when U >= 5 and does not depend on the carry in. The low bit depends on the carry in only through the carry in's high bit.
- R6: For every column: x + y + z + c = (A - 6) + B + 10 × (carry out).
- R7: For every column, (A - 6) + B lies in [0, 18], which means A + B lies in [6, 24].
- R8: The carry into column 0 is zero. The carry into column i is the carry out of column i-1. The carry out of the most significant column appears on `carry_out`.
- R9: The sum over all columns of (x+y+z)·10^i equals the sum of ((A-6)+B)·10^i plus `carry_out`·10^NUM_COLS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| dig_x | input | 4·NUM_COLS | First redundant digit vector, each digit 0..15 |
| dig_y | input | 4·NUM_COLS | Second redundant digit vector |
| dig_z | input | 4·NUM_COLS | Third redundant digit vector |
| sum_xs6 | output | 4·NUM_COLS | Excess-6 A digits |
| sum_bcd | output | 4·NUM_COLS | BCD B digits |
| carry_out | output | 2 | Decimal carry out of the top column |

## Verification
The properties take for granted that every input digit may hold any 4-bit value. They place no coding restriction on the inputs, and they rely only on the registered outputs having been loaded from inputs sampled one edge earlier, after reset has been released. The stimulus drives the full 0..15 range on every digit. It sweeps all digit triples of the top column against each of the four possible carry-in values, which it sets up by choosing the upper bits in the column below. It then adds random full-width vectors, so that carries between columns are exercised in every combination.

// File: rtl/dcmp_pkg.sv
package dcmp_pkg;
    localparam int DIGIT_W  = 4;
    localparam int CARRY_W  = 2;
    localparam int EXCESS   = 6;

    typedef logic [DIGIT_W-1:0] digit_t;
    typedef logic [CARRY_W-1:0] dcarry_t;
endpackage

// File: rtl/dcmp_upper_sum.sv
// Adds the weight-8/weight-4 bit pairs of three digits as 2-bit values (result 0..9).
module dcmp_upper_sum
    import dcmp_pkg::*;
(
    input  digit_t x,
    input  digit_t y,
    input  digit_t z,
    output logic [3:0] usum
);
    always_comb begin
        usum = {2'b00, x[3:2]} + {2'b00, y[3:2]} + {2'b00, z[3:2]};
    end
endmodule

// File: rtl/dcmp_lower_sum.sv
// Adds the weight-2/weight-1 bit pairs of three digits; the result is at most 9.
module dcmp_lower_sum
    import dcmp_pkg::*;
(
    input  digit_t x,
    input  digit_t y,
    input  digit_t z,
    output digit_t lsum
);
    always_comb begin
        lsum = {2'b00, x[1:0]} + {2'b00, y[1:0]} + {2'b00, z[1:0]};
    end
endmodule

// File: rtl/dcmp_column.sv
// One decimal column: splits the three digits by bit weight and forms the A, B and carry outputs.
module dcmp_column
    import dcmp_pkg::*;
(
    input  digit_t  x,
    input  digit_t  y,
    input  digit_t  z,
    input  dcarry_t cin,
    output digit_t  a_xs6,
    output digit_t  b_bcd,
    output dcarry_t cout
);
    logic [3:0] usum;
    digit_t     lsum;
    logic [5:0] upper_val;
    logic [5:0] tens_val;
    logic [5:0] a_true;
    logic       cout_hi;
    logic       cout_lo;

    dcmp_upper_sum u_upper (.x(x), .y(y), .z(z), .usum(usum));
    dcmp_lower_sum u_lower (.x(x), .y(y), .z(z), .lsum(lsum));

    always_comb begin
        // High carry bit: 4*U + c reaches 20 only when U >= 5, for any c <= 3.
        cout_hi = (usum >= 4'd5);
        // Low carry bit: fixed by U, except at U = 2 or 7, where c >= 2 crosses a ten.
        unique case (usum)
            4'd3, 4'd4, 4'd8, 4'd9: cout_lo = 1'b1;
            4'd2, 4'd7:             cout_lo = cin[1];
            default:                cout_lo = 1'b0;
        endcase
        cout      = {cout_hi, cout_lo};
        upper_val = {usum, 2'b00} + {4'b0000, cin};
        unique case (cout)
            2'd0:    tens_val = 6'd0;
            2'd1:    tens_val = 6'd10;
            2'd2:    tens_val = 6'd20;
            default: tens_val = 6'd30;
        endcase
        a_true = upper_val - tens_val;
        a_xs6  = a_true[3:0] + digit_t'(EXCESS);
        b_bcd  = lsum;
    end
endmodule

// File: rtl/dec_csa32.sv
module dec_csa32
    import dcmp_pkg::*;
#(
    parameter int NUM_COLS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_COLS*DIGIT_W-1:0]   dig_x,
    input  logic [NUM_COLS*DIGIT_W-1:0]   dig_y,
    input  logic [NUM_COLS*DIGIT_W-1:0]   dig_z,
    output logic [NUM_COLS*DIGIT_W-1:0]   sum_xs6,
    output logic [NUM_COLS*DIGIT_W-1:0]   sum_bcd,
    output logic [CARRY_W-1:0]            carry_out
);
    localparam int VEC_W = NUM_COLS * DIGIT_W;

    typedef struct packed {
        logic [VEC_W-1:0]   a;
        logic [VEC_W-1:0]   b;
        logic [CARRY_W-1:0] c;
    } stage_t;

    dcarry_t          chain [NUM_COLS+1];
    logic [VEC_W-1:0] col_a;
    logic [VEC_W-1:0] col_b;
    stage_t           stage_d;
    stage_t           stage_q;

    assign chain[0] = '0;

    for (genvar i = 0; i < NUM_COLS; i++) begin : g_col
        dcmp_column u_col (
            .x     (dig_x[i*DIGIT_W +: DIGIT_W]),
            .y     (dig_y[i*DIGIT_W +: DIGIT_W]),
            .z     (dig_z[i*DIGIT_W +: DIGIT_W]),
            .cin   (chain[i]),
            .a_xs6 (col_a[i*DIGIT_W +: DIGIT_W]),
            .b_bcd (col_b[i*DIGIT_W +: DIGIT_W]),
            .cout  (chain[i+1])
        );
    end

    always_comb begin
        stage_d   = stage_q;
        stage_d.a = col_a;
        stage_d.b = col_b;
        stage_d.c = chain[NUM_COLS];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign sum_xs6   = stage_q.a;
    assign sum_bcd   = stage_q.b;
    assign carry_out = stage_q.c;
endmodule

// File: rtl/dec_csa32_checker.sv
module dec_csa32_checker
    import dcmp_pkg::*;
#(
    parameter int NUM_COLS = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_COLS*DIGIT_W-1:0] dig_x,
    input logic [NUM_COLS*DIGIT_W-1:0] dig_y,
    input logic [NUM_COLS*DIGIT_W-1:0] dig_z,
    input logic [NUM_COLS*DIGIT_W-1:0] sum_xs6,
    input logic [NUM_COLS*DIGIT_W-1:0] sum_bcd,
    input logic [CARRY_W-1:0]          carry_out
);
    localparam int VEC_W = NUM_COLS * DIGIT_W;
    localparam int TOP   = (NUM_COLS - 1) * DIGIT_W;

    logic armed_q;
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    function automatic longint total_in(input logic [VEC_W-1:0] x, y, z);
        longint acc = 0;
        longint w   = 1;
        for (int i = 0; i < NUM_COLS; i++) begin
            acc += w * longint'(x[i*DIGIT_W +: DIGIT_W] + 5'd0
                              + y[i*DIGIT_W +: DIGIT_W] + z[i*DIGIT_W +: DIGIT_W]);
            w *= 10;
        end
        return acc;
    endfunction

    function automatic longint total_out(input logic [VEC_W-1:0] a, b, input logic [1:0] c);
        longint acc = 0;
        longint w   = 1;
        for (int i = 0; i < NUM_COLS; i++) begin
            acc += w * (longint'(a[i*DIGIT_W +: DIGIT_W]) - EXCESS + longint'(b[i*DIGIT_W +: DIGIT_W]));
            w *= 10;
        end
        return acc + w * longint'(c);
    endfunction

    function automatic logic ranges_ok(input logic [VEC_W-1:0] a, b);
        logic ok = 1'b1;
        for (int i = 0; i < NUM_COLS; i++) begin
            if (a[i*DIGIT_W +: DIGIT_W] < 4'd6) ok = 1'b0;
            if (b[i*DIGIT_W +: DIGIT_W] > 4'd9) ok = 1'b0;
            if ((5'(a[i*DIGIT_W +: DIGIT_W]) + 5'(b[i*DIGIT_W +: DIGIT_W])) > 5'd24) ok = 1'b0;
        end
        return ok;
    endfunction

    function automatic logic [3:0] upper_top(input logic [VEC_W-1:0] x, y, z);
        return {2'b00, x[TOP+2 +: 2]} + {2'b00, y[TOP+2 +: 2]} + {2'b00, z[TOP+2 +: 2]};
    endfunction

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (sum_xs6 == '0 && sum_bcd == '0 && carry_out == '0)); // R1

    AST_DIGIT_RANGES: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> ranges_ok(sum_xs6, sum_bcd)); // R7

    AST_TOTAL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> total_out(sum_xs6, sum_bcd, carry_out)
                    == total_in($past(dig_x), $past(dig_y), $past(dig_z))); // R9

    AST_CARRY_HIGH_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> carry_out[1] == (upper_top($past(dig_x), $past(dig_y), $past(dig_z)) >= 4'd5)); // R5

    AST_OUTPUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $stable(dig_x) && $stable(dig_y) && $stable(dig_z)) |=>
            ($stable(sum_xs6) && $stable(sum_bcd) && $stable(carry_out))); // R1
endmodule

bind dec_csa32 dec_csa32_checker #(.NUM_COLS(NUM_COLS)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .dig_x     (dig_x),
    .dig_y     (dig_y),
    .dig_z     (dig_z),
    .sum_xs6   (sum_xs6),
    .sum_bcd   (sum_bcd),
    .carry_out (carry_out)
);

// File: tb/dec_csa32_test.sv
`timescale 1ns/1ps
module dec_csa32_test;
    localparam int N     = 4;
    localparam int VW    = N * 4;
    localparam int TOPB  = (N - 1) * 4;

    typedef struct {
        logic [VW-1:0] x, y, z;
        logic [VW-1:0] ea, eb;
        logic [1:0]    ec;
        int            top_cin;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [VW-1:0] dig_x = '1, dig_y = '1, dig_z = '1;
    logic [VW-1:0] sum_xs6, sum_bcd;
    logic [1:0]    carry_out;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;
    item_t sb[$];
    item_t cur;

    dec_csa32 #(.NUM_COLS(N)) uut (
        .clk(clk), .rst_n(rst_n), .dig_x(dig_x), .dig_y(dig_y), .dig_z(dig_z),
        .sum_xs6(sum_xs6), .sum_bcd(sum_bcd), .carry_out(carry_out)
    );

    always #2.5 clk = ~clk;

    // Reference model written from the requirements (R2, R3, R4, R8).
    task automatic ref_model(input logic [VW-1:0] x, y, z, output item_t it);
        int cin = 0;
        it.x = x; it.y = y; it.z = z;
        it.top_cin = 0;
        for (int i = 0; i < N; i++) begin
            int u = int'(x[i*4+2 +: 2]) + int'(y[i*4+2 +: 2]) + int'(z[i*4+2 +: 2]);
            int l = int'(x[i*4 +: 2]) + int'(y[i*4 +: 2]) + int'(z[i*4 +: 2]);
            int v = 4 * u + cin;
            if (i == N - 1) it.top_cin = cin;
            it.ea[i*4 +: 4] = 4'((v % 10) + 6);
            it.eb[i*4 +: 4] = 4'(l);
            cin = v / 10;
        end
        it.ec = 2'(cin);
    endtask

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic [VW-1:0] x, y, z);
        item_t it;
        @(negedge clk);
        dig_x = x; dig_y = y; dig_z = z;
        ref_model(x, y, z, it);
        sb.push_back(it);
    endtask

    // Monitor: outputs for the item pushed at the previous falling edge are valid just after the rising edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && sb.size() > 0) begin
            longint tin, tout, w;
            int tx, ty, tz, ta, tb;
            bit rng;
            cur = sb.pop_front();
            check(sum_xs6 == cur.ea, "R3 A digits", longint'(sum_xs6), longint'(cur.ea));
            check(sum_bcd == cur.eb, "R2 B digits", longint'(sum_bcd), longint'(cur.eb));
            check(carry_out == cur.ec, "R4/R8 top carry", longint'(carry_out), longint'(cur.ec));
            tin = 0; tout = 0; w = 1; rng = 1'b1;
            for (int i = 0; i < N; i++) begin
                tin  += w * longint'(int'(cur.x[i*4 +: 4]) + int'(cur.y[i*4 +: 4]) + int'(cur.z[i*4 +: 4]));
                tout += w * longint'(int'(sum_xs6[i*4 +: 4]) - 6 + int'(sum_bcd[i*4 +: 4]));
                if (sum_xs6[i*4 +: 4] < 6 || sum_bcd[i*4 +: 4] > 9) rng = 1'b0;
                if (int'(sum_xs6[i*4 +: 4]) + int'(sum_bcd[i*4 +: 4]) > 24) rng = 1'b0;
                w *= 10;
            end
            tout += w * longint'(carry_out);
            check(tout == tin, "R9 weighted total", tout, tin);
            check(rng, "R7 digit ranges", longint'({sum_xs6, sum_bcd}), 0);
            tx = int'(cur.x[TOPB +: 4]); ty = int'(cur.y[TOPB +: 4]); tz = int'(cur.z[TOPB +: 4]);
            ta = int'(sum_xs6[TOPB +: 4]); tb = int'(sum_bcd[TOPB +: 4]);
            check(tx + ty + tz + cur.top_cin == ta - 6 + tb + 10 * int'(carry_out),
                  "R6 column identity", ta - 6 + tb + 10 * int'(carry_out), tx + ty + tz + cur.top_cin);
            check(carry_out[1] == ((int'(cur.x[TOPB+2 +: 2]) + int'(cur.y[TOPB+2 +: 2])
                                   + int'(cur.z[TOPB+2 +: 2])) >= 5),
                  "R5 carry high bit", longint'(carry_out[1]), 0);
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        // Column below the top sets the top column's carry in: U = 0, 3, 5, 8 give carry 0..3.
        logic [3:0] cx [4];
        logic [3:0] cy [4];
        logic [3:0] cz [4];
        cx = '{4'd0, 4'd12, 4'd12, 4'd12};
        cy = '{4'd0, 4'd0,  4'd8,  4'd12};
        cz = '{4'd0, 4'd0,  4'd0,  4'd8};
        repeat (3) @(posedge clk);
        #1;
        check(sum_xs6 == '0, "R1 reset A", longint'(sum_xs6), 0);
        check(sum_bcd == '0, "R1 reset B", longint'(sum_bcd), 0);
        check(carry_out == '0, "R1 reset carry", longint'(carry_out), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // Exhaustive sweep of the top column against each carry in.
        for (int c = 0; c < 4; c++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    for (int d = 0; d < 16; d++) begin
                        logic [VW-1:0] vx, vy, vz;
                        vx = '0; vy = '0; vz = '0;
                        vx[TOPB-4 +: 4] = cx[c]; vy[TOPB-4 +: 4] = cy[c]; vz[TOPB-4 +: 4] = cz[c];
                        vx[TOPB +: 4] = 4'(a); vy[TOPB +: 4] = 4'(b); vz[TOPB +: 4] = 4'(d);
                        drive(vx, vy, vz);
                    end
                end
            end
        end
        // Corner vectors: all ones and all zeros.
        drive('1, '1, '1);
        drive('0, '0, '0);
        // Random full-width vectors exercise every inter-column carry.
        for (int k = 0; k < 3000; k++) begin
            drive(VW'($urandom), VW'($urandom), VW'($urandom));
        end
        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule